// File: doc/BRIEF.md
# Ringing Cadence Controller

This block paces telephone ringing as alternating bursts and pauses. A line-state command selects what the line should be doing. While that command holds the ringing code, the block keeps a ring-enable output high for a programmed active interval. It then drops the output and reports on-hook transmission for a programmed silent interval, after which ringing starts again. The waveform generator downstream reads the ring-enable output. The same cadence applies to any waveform shape it produces.

The two intervals are counted in ticks of roughly one millisecond. An internal prescaler divides the system clock to make these ticks, and it restarts at the start of every phase. Each interval timer has its own enable. With the active timer disabled, ringing lasts until the command changes. With the silent timer disabled, the line stays in on-hook transmission after the first burst. Each interval expiry produces a one-cycle event pulse, which can be used as an interrupt source.

Top module: `ring_cad_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ring_on`, `act_expire` and `inact_expire` are 0.
- R2: The line-state code for ringing is 3'd4. When `line_cmd` becomes 3'd4 with no cadence running, `ring_on` is 1 in the cycle after the command is seen at a clock edge.
- R3: With `act_en` set, `ring_on` stays high for exactly `act_ms` × `TICK_DIV` clock cycles.
- R4: At the end of the active interval, `ring_on` falls and `line_state` reports on-hook transmission (code 3'd2). `act_expire` is high for exactly one cycle, and that cycle is the first cycle with `ring_on` low.
- R5: With `inact_en` set, the silent phase lasts `inact_ms` × `TICK_DIV` cycles. Then `ring_on` rises again, and `inact_expire` pulses for one cycle, in the first cycle of the new burst.
- R6: With `act_en` clear, `ring_on` stays high and `act_expire` stays low for as long as `line_cmd` remains 3'd4.
- R7: With `inact_en` clear, the silent phase never ends. `ring_on` stays low and `line_state` stays 3'd2 while `line_cmd` remains 3'd4.
- R8: When `line_cmd` leaves 3'd4, `ring_on` is low from the next cycle on, and both timers are reset. A later ringing command starts a full active interval.
- R9: An interval value of zero expires on the first tick of its phase, so the phase lasts `TICK_DIV` cycles.
- R10: While `line_cmd` is not 3'd4, `line_state` equals `line_cmd`. While it is 3'd4, `line_state` is 3'd4 during bursts and 3'd2 during the silent phase.
- R11: Interval values up to 8000 ticks (8 s at 1 ms) are timed exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cmd | input | 3 | Commanded line state (3'd4 = ringing) |
| act_en | input | 1 | Enable for the active (ringing) interval timer |
| inact_en | input | 1 | Enable for the silent interval timer |
| act_ms | input | 16 | Active interval, in ticks |
| inact_ms | input | 16 | Silent interval, in ticks |
| ring_on | output | 1 | Ring enable to the waveform generator |
| line_state | output | 3 | Reported line state |
| act_expire | output | 1 | One-cycle pulse when the active interval expires |
| inact_expire | output | 1 | One-cycle pulse when the silent interval expires |

## Verification
The bench measures burst and pause lengths in clock cycles.
- An off-by-one in the tick prescaler or the down-counter would lengthen or shorten each phase by one tick.
- Zero-valued intervals are driven to catch a counter that wraps to 65535 instead of expiring at once.
- Ringing is aborted mid-burst and then restarted, to expose timers that resume from a stale count instead of reloading.
- Each enable is cleared in turn, to catch a design that keeps cycling or stops ringing when one timer is off.
- An 8000-tick interval exercises the full range without truncation.

// File: rtl/ring_cad_pkg.sv
package ring_cad_pkg;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_RING   = 2'd1,
        PH_SILENT = 2'd2
    } phase_e;

    localparam int          LS_W    = 3;
    localparam logic [2:0]  LS_RING = 3'd4;
    localparam logic [2:0]  LS_OHT  = 3'd2;

    localparam int N_TMR   = 2;
    localparam int TMR_ACT = 0;
    localparam int TMR_SIL = 1;

    function automatic logic is_ring(input logic [LS_W-1:0] code);
        return code == LS_RING;
    endfunction

endpackage

// File: rtl/ring_cad_prescale.sv
module ring_cad_prescale #(
    parameter int DIV = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    assign tick = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ring_cad_timer.sv
module ring_cad_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    input  logic         tick,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    // zero and one both end the phase on the next tick
    assign expire = run && tick && (cnt <= ONE);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && tick && !expire)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ring_cad_seq.sv
module ring_cad_seq
    import ring_cad_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cmd_ring,
    input  logic   act_exp,
    input  logic   sil_exp,
    output phase_e phase,
    output logic   load_act,
    output logic   load_sil,
    output logic   pre_clr,
    output logic   tmr_clr
);
    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        load_act = 1'b0;
        load_sil = 1'b0;
        if (!cmd_ring) begin
            phase_nx = PH_OFF;
        end else begin
            unique case (phase)
                PH_OFF: begin
                    phase_nx = PH_RING;
                    load_act = 1'b1;
                end
                PH_RING: if (act_exp) begin
                    phase_nx = PH_SILENT;
                    load_sil = 1'b1;
                end
                PH_SILENT: if (sil_exp) begin
                    phase_nx = PH_RING;
                    load_act = 1'b1;
                end
                default: phase_nx = PH_OFF;
            endcase
        end
    end

    assign tmr_clr = !cmd_ring;
    assign pre_clr = !cmd_ring || (phase == PH_OFF) || load_act || load_sil;

    always_ff @(posedge clk) begin
        if (rst)
            phase <= PH_OFF;
        else
            phase <= phase_nx;
    end
endmodule

// File: rtl/ring_cad_ctrl.sv
module ring_cad_ctrl
    import ring_cad_pkg::*;
#(
    parameter int TICK_DIV = 200000,
    parameter int TMR_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       line_cmd,
    input  logic             act_en,
    input  logic             inact_en,
    input  logic [TMR_W-1:0] act_ms,
    input  logic [TMR_W-1:0] inact_ms,
    output logic             ring_on,
    output logic [2:0]       line_state,
    output logic             act_expire,
    output logic             inact_expire
);
    logic   cmd_ring;
    logic   tick;
    logic   pre_clr;
    logic   tmr_clr;
    logic   load_act;
    logic   load_sil;
    phase_e phase;

    logic [N_TMR-1:0] t_run;
    logic [N_TMR-1:0] t_load;
    logic [N_TMR-1:0] t_exp;
    logic [TMR_W-1:0] t_val [N_TMR];

    assign cmd_ring = is_ring(line_cmd);

    ring_cad_prescale #(.DIV(TICK_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (pre_clr),
        .tick (tick)
    );

    ring_cad_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .cmd_ring (cmd_ring),
        .act_exp  (t_exp[TMR_ACT]),
        .sil_exp  (t_exp[TMR_SIL]),
        .phase    (phase),
        .load_act (load_act),
        .load_sil (load_sil),
        .pre_clr  (pre_clr),
        .tmr_clr  (tmr_clr)
    );

    assign t_run[TMR_ACT]  = (phase == PH_RING)   && act_en;
    assign t_run[TMR_SIL]  = (phase == PH_SILENT) && inact_en;
    assign t_load[TMR_ACT] = load_act;
    assign t_load[TMR_SIL] = load_sil;
    assign t_val[TMR_ACT]  = act_ms;
    assign t_val[TMR_SIL]  = inact_ms;

    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
        ring_cad_timer #(.W(TMR_W)) u_tmr (
            .clk      (clk),
            .rst      (rst),
            .clr      (tmr_clr),
            .load     (t_load[g]),
            .load_val (t_val[g]),
            .run      (t_run[g]),
            .tick     (tick),
            .expire   (t_exp[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_expire   <= 1'b0;
            inact_expire <= 1'b0;
        end else begin
            act_expire   <= t_exp[TMR_ACT] && cmd_ring;
            inact_expire <= t_exp[TMR_SIL] && cmd_ring;
        end
    end

    assign ring_on    = (phase == PH_RING);
    assign line_state = (cmd_ring && phase == PH_SILENT) ? LS_OHT : line_cmd;
endmodule

// File: rtl/ring_cad_sva.sv
module ring_cad_sva
    import ring_cad_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] line_cmd,
    input logic       act_en,
    input logic       inact_en,
    input logic       ring_on,
    input logic [2:0] line_state,
    input logic       act_expire,
    input logic       inact_expire
);
    // R8: leaving the ringing command silences the output at the next edge
    p_leave_r8: assert property (@(posedge clk) disable iff (rst)
        (line_cmd != LS_RING) |=> !ring_on);

    // R4: active expiry pulse is a single cycle and coincides with ring off
    p_act_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        act_expire |=> !act_expire);
    p_act_off_r4: assert property (@(posedge clk) disable iff (rst)
        act_expire |-> !ring_on);

    // R5: silent expiry pulse is a single cycle in the first burst cycle
    p_sil_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        inact_expire |=> !inact_expire);
    p_sil_on_r5: assert property (@(posedge clk) disable iff (rst)
        inact_expire |-> ring_on);

    // R4: ringing ends only by expiry or by a command change
    p_fall_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ring_on) |-> (act_expire || $past(line_cmd) != LS_RING));

    // R6: active timer disabled keeps the burst going
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ring_on && !act_en && line_cmd == LS_RING) |=> ring_on);

    // R7: silent timer disabled keeps the line quiet
    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!ring_on && line_state == LS_OHT && line_cmd == LS_RING && !inact_en)
        |=> !ring_on);

    // R10: a non-ringing command is reported unchanged
    p_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (line_cmd != LS_RING) |-> (line_state == line_cmd));
endmodule

bind ring_cad_ctrl ring_cad_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .line_cmd     (line_cmd),
    .act_en       (act_en),
    .inact_en     (inact_en),
    .ring_on      (ring_on),
    .line_state   (line_state),
    .act_expire   (act_expire),
    .inact_expire (inact_expire)
);

// File: tb/ring_cad_ctrl_bench.sv
module ring_cad_ctrl_bench;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  line_cmd = 3'd0;
    logic        act_en = 1'b0;
    logic        inact_en = 1'b0;
    logic [15:0] act_ms = 16'd0;
    logic [15:0] inact_ms = 16'd0;
    logic        ring_on;
    logic [2:0]  line_state;
    logic        act_expire;
    logic        inact_expire;

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ring_cad_ctrl #(.TICK_DIV(DIV), .TMR_W(16)) u_ring_cad_ctrl (
        .clk(clk), .rst(rst), .line_cmd(line_cmd), .act_en(act_en),
        .inact_en(inact_en), .act_ms(act_ms), .inact_ms(inact_ms),
        .ring_on(ring_on), .line_state(line_state),
        .act_expire(act_expire), .inact_expire(inact_expire)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: phase 0 off, 1 ringing, 2 silent
    int m_ph = 0, m_pre = 0, m_left = 0;
    bit m_ea = 0, m_ei = 0;

    always @(posedge clk) begin
        bit tk;
        m_ea = 0;
        m_ei = 0;
        tk = (m_pre == DIV - 1);
        if (rst || line_cmd != 3'd4) begin
            m_ph = 0; m_pre = 0; m_left = 0;
        end else if (m_ph == 0) begin
            m_ph = 1; m_pre = 0; m_left = act_ms;
        end else begin
            bit en;
            en = (m_ph == 1) ? act_en : inact_en;
            if (en && tk && m_left <= 1) begin
                if (m_ph == 1) begin m_ph = 2; m_left = inact_ms; m_ea = 1; end
                else           begin m_ph = 1; m_left = act_ms;   m_ei = 1; end
                m_pre = 0;
            end else begin
                m_pre = tk ? 0 : m_pre + 1;
                if (en && tk) m_left--;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int exp_ls;
            exp_ls = (line_cmd == 3'd4 && m_ph == 2) ? 2 : line_cmd;
            chk(cur_req, "model ring_on", ring_on, m_ph == 1);
            chk(cur_req, "model line_state", line_state, exp_ls);
            chk(cur_req, "model act_expire", act_expire, m_ea);
            chk(cur_req, "model inact_expire", inact_expire, m_ei);
        end
    end

    task automatic count_level(input bit lvl, input int limit, output int n);
        n = 0;
        while (ring_on == lvl && n < limit) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic idle(input int n);
        line_cmd = 3'd0;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        int watch = 0;
        forever begin
            @(posedge clk);
            watch++;
            if (watch > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", watch);
                finish_run();
            end
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ring_on in reset", ring_on, 0);
        chk("R1", "act_expire in reset", act_expire, 0);
        chk("R1", "inact_expire in reset", inact_expire, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ring_on after reset", ring_on, 0);

        // R10: pass-through of non-ringing codes
        cur_req = "R10";
        line_cmd = 3'd1;
        @(negedge clk);
        chk("R10", "line_state passthrough", line_state, 1);
        chk("R10", "ring_on idle", ring_on, 0);

        // R2 R3 R4 R5: basic cadence 3 on / 2 off
        cur_req = "R3";
        act_ms = 16'd3; inact_ms = 16'd2; act_en = 1'b1; inact_en = 1'b1;
        line_cmd = 3'd4;
        @(negedge clk);
        chk("R2", "ring_on after command", ring_on, 1);
        chk("R10", "line_state while ringing", line_state, 4);
        count_level(1'b1, 1000, n);
        chk("R3", "burst length", n, 3 * DIV);
        chk("R4", "act_expire at end of burst", act_expire, 1);
        chk("R4", "line_state on-hook tx", line_state, 2);
        @(negedge clk);
        chk("R4", "act_expire single cycle", act_expire, 0);
        cur_req = "R5";
        count_level(1'b0, 1000, n);
        chk("R5", "silent length", n + 1, 2 * DIV);
        chk("R5", "inact_expire at restart", inact_expire, 1);
        count_level(1'b1, 1000, n);
        chk("R5", "second burst length", n, 3 * DIV);
        idle(3);

        // R9: zero intervals
        cur_req = "R9";
        act_ms = 16'd0; inact_ms = 16'd0;
        line_cmd = 3'd4;
        @(negedge clk);
        count_level(1'b1, 1000, n);
        chk("R9", "zero burst length", n, DIV);
        count_level(1'b0, 1000, n);
        chk("R9", "zero silent length", n, DIV);
        idle(3);

        // R6: active timer disabled
        cur_req = "R6";
        act_ms = 16'd1; act_en = 1'b0;
        line_cmd = 3'd4;
        @(negedge clk);
        count_level(1'b1, 200, n);
        chk("R6", "continuous ringing", n, 200);
        // R8: abort
        cur_req = "R8";
        line_cmd = 3'd3;
        @(negedge clk);
        chk("R8", "ring_on after abort", ring_on, 0);
        chk("R8", "line_state after abort", line_state, 3);
        idle(2);

        // R7: silent timer disabled
        cur_req = "R7";
        act_en = 1'b1; inact_en = 1'b0; act_ms = 16'd1; inact_ms = 16'd1;
        line_cmd = 3'd4;
        @(negedge clk);
        count_level(1'b1, 1000, n);
        chk("R7", "short burst", n, DIV);
        count_level(1'b0, 200, n);
        chk("R7", "silence holds", n, 200);
        chk("R7", "line_state stays on-hook tx", line_state, 2);
        idle(2);

        // R8: mid-burst abort then full restart
        cur_req = "R8";
        inact_en = 1'b1; act_ms = 16'd5;
        line_cmd = 3'd4;
        repeat (7) @(negedge clk);
        line_cmd = 3'd2;
        @(negedge clk);
        chk("R8", "ring_on low mid-burst abort", ring_on, 0);
        line_cmd = 3'd4;
        @(negedge clk);
        count_level(1'b1, 1000, n);
        chk("R8", "restart full interval", n, 5 * DIV);
        idle(3);

        // R11: long interval
        cur_req = "R11";
        act_ms = 16'd8000;
        line_cmd = 3'd4;
        @(negedge clk);
        count_level(1'b1, 40000, n);
        chk("R11", "8000 tick burst", n, 8000 * DIV);
        chk("R11", "act_expire after long burst", act_expire, 1);
        idle(3);

        finish_run();
    end
endmodule